// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter for an 8-bit microcontroller core that has a 16-bit code space. The core has already decoded the instruction and advanced the program counter past it. It hands the block a transfer class code together with every operand field the transfer might use: an 11-bit in-page address, a 16-bit long address, an 8-bit signed displacement, the accumulator and the 16-bit data pointer. For conditional transfers the core also supplies the condition result it has already evaluated. The block selects the candidate address for that class and registers it with a taken flag.

The block supports four kinds of target. An in-page absolute target keeps the top five bits of the advanced program counter and fills in the low eleven bits from the instruction. A long target is the full 16-bit address from the instruction. A relative target adds a sign-extended displacement to the advanced program counter. An indexed target adds the unsigned accumulator to the data pointer. A conditional relative transfer whose condition is false, or an unused class code, gives the advanced program counter and a low taken flag. All sums wrap modulo 2^16. The result is captured on a rising clock edge when the valid strobe is high. It holds its value at any other time.

Top module: `bta_gen`

## Requirements
- R1: A synchronous active-high reset sets target_o to 0x0000 and taken_o to 0.
- R2: For class code 3'd0 (in-page absolute), after a valid edge target_o = {pc_next_i[15:11], page_i[10:0]} and taken_o = 1, whatever cond_i is.
- R3: The in-page absolute target takes its upper bits from pc_next_i, the address after the transfer instruction. A 2-byte transfer at 0x07FE (pc_next_i = 0x0800) therefore lands in the page at 0x0800, not the one at 0x0000.
- R4: For class code 3'd1 (long), after a valid edge target_o = long_i and taken_o = 1, whatever cond_i is.
- R5: For class code 3'd2 (unconditional short relative), after a valid edge target_o = pc_next_i + sign-extended disp_i, mod 2^16, and taken_o = 1, whatever cond_i is.
- R6: For class code 3'd3 (conditional relative) with cond_i = 1, after a valid edge target_o = pc_next_i + sign-extended disp_i, mod 2^16, and taken_o = 1.
- R7: For class code 3'd3 with cond_i = 0, after a valid edge target_o = pc_next_i and taken_o = 0.
- R8: For class code 3'd4 (indexed), after a valid edge target_o = dptr_i + zero-extended acc_i, mod 2^16, and taken_o = 1.
- R9: Class codes 3'd5, 3'd6 and 3'd7 give target_o = pc_next_i and taken_o = 0 after a valid edge.
- R10: While valid_i is low, target_o and taken_o keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Capture strobe for the selected target |
| cls_i | input | 3 | Transfer class code |
| cond_i | input | 1 | Evaluated condition for conditional relative transfers |
| pc_next_i | input | 16 | Address of the instruction after the transfer |
| page_i | input | 11 | In-page absolute address field |
| long_i | input | 16 | Long absolute address |
| disp_i | input | 8 | Signed relative displacement |
| acc_i | input | 8 | Accumulator, used as unsigned index |
| dptr_i | input | 16 | Data pointer base for indexed transfers |
| target_o | output | 16 | Registered target address |
| taken_o | output | 1 | Registered taken flag |

## Verification
The hardest cases to reach are the ones where an address crosses a boundary. One is an in-page transfer whose advanced program counter has just entered a new 2K page. The others are relative and indexed sums that wrap past 0xFFFF or below 0x0000. Uniform random operands hit these only rarely, so directed cases set pc_next_i exactly to a page start such as 0x0800, and put displacements of 0x80 and 0x7F and index values up to 0xFF next to the ends of the address space. Randomized rounds then mix every class code with random valid and cond_i values. This covers the hold and not-taken paths between captures.

// File: rtl/bta_pkg.sv
package bta_pkg;

    localparam int ADDR_W = 16;
    localparam int PAGE_W = 11;
    localparam int DISP_W = 8;
    localparam int IDX_W  = 8;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        XF_PAGE  = 3'd0,
        XF_LONG  = 3'd1,
        XF_REL   = 3'd2,
        XF_CREL  = 3'd3,
        XF_INDEX = 3'd4
    } xfer_cls_e;

    // One-hot source choice produced by the class decoder.
    typedef struct packed {
        logic use_page;
        logic use_long;
        logic use_rel;
        logic use_index;
        logic use_seq;
    } src_sel_t;

    typedef struct packed {
        src_sel_t sel;
        logic     taken;
    } xfer_dec_t;

    function automatic xfer_dec_t decode_cls(input logic [CLS_W-1:0] cls,
                                             input logic cond);
        xfer_dec_t d;
        d = '0;
        case (cls)
            XF_PAGE:  begin d.sel.use_page  = 1'b1; d.taken = 1'b1; end
            XF_LONG:  begin d.sel.use_long  = 1'b1; d.taken = 1'b1; end
            XF_REL:   begin d.sel.use_rel   = 1'b1; d.taken = 1'b1; end
            XF_CREL:  begin
                d.sel.use_rel = cond;
                d.sel.use_seq = ~cond;
                d.taken       = cond;
            end
            XF_INDEX: begin d.sel.use_index = 1'b1; d.taken = 1'b1; end
            default:  begin d.sel.use_seq   = 1'b1; d.taken = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bta_page_unit.sv
module bta_page_unit #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 11
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [PAGE_W-1:0] page_field,
    output logic [ADDR_W-1:0] page_addr
);
    localparam int HI_W = ADDR_W - PAGE_W;

    generate
        if (HI_W > 0) begin : g_split
            assign page_addr = {pc_next[ADDR_W-1:PAGE_W], page_field};
        end else begin : g_full
            assign page_addr = page_field[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bta_offset_adder.sv
module bta_offset_adder #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ext_off;

    generate
        if (SIGNED) begin : g_sext
            assign ext_off = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_zext
            assign ext_off = {{EXT_W{1'b0}}, offset};
        end
    endgenerate

    // Carry out is dropped: arithmetic wraps modulo 2^ADDR_W.
    assign sum = base + ext_off;
endmodule

// File: rtl/bta_select.sv
module bta_select
    import bta_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  src_sel_t          sel,
    input  logic [ADDR_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] long_addr,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [ADDR_W-1:0] idx_addr,
    input  logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] chosen
);
    // AND-OR mux: the decoder guarantees a one-hot select.
    always_comb begin
        chosen = ({ADDR_W{sel.use_page}}  & page_addr)
               | ({ADDR_W{sel.use_long}}  & long_addr)
               | ({ADDR_W{sel.use_rel}}   & rel_addr)
               | ({ADDR_W{sel.use_index}} & idx_addr)
               | ({ADDR_W{sel.use_seq}}   & seq_addr);
    end
endmodule

// File: rtl/bta_gen.sv
module bta_gen
    import bta_pkg::*;
#(
    parameter int A_W = bta_pkg::ADDR_W,
    parameter int P_W = bta_pkg::PAGE_W,
    parameter int D_W = bta_pkg::DISP_W,
    parameter int X_W = bta_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [2:0]       cls_i,
    input  logic             cond_i,
    input  logic [A_W-1:0]   pc_next_i,
    input  logic [P_W-1:0]   page_i,
    input  logic [A_W-1:0]   long_i,
    input  logic [D_W-1:0]   disp_i,
    input  logic [X_W-1:0]   acc_i,
    input  logic [A_W-1:0]   dptr_i,
    output logic [A_W-1:0]   target_o,
    output logic             taken_o
);
    xfer_dec_t      dec;
    logic [A_W-1:0] page_addr;
    logic [A_W-1:0] rel_addr;
    logic [A_W-1:0] idx_addr;
    logic [A_W-1:0] chosen;

    assign dec = decode_cls(cls_i, cond_i);

    bta_page_unit #(.ADDR_W(A_W), .PAGE_W(P_W)) u_page (
        .pc_next    (pc_next_i),
        .page_field (page_i),
        .page_addr  (page_addr)
    );

    bta_offset_adder #(.ADDR_W(A_W), .OFF_W(D_W), .SIGNED(1'b1)) u_rel (
        .base   (pc_next_i),
        .offset (disp_i),
        .sum    (rel_addr)
    );

    bta_offset_adder #(.ADDR_W(A_W), .OFF_W(X_W), .SIGNED(1'b0)) u_idx (
        .base   (dptr_i),
        .offset (acc_i),
        .sum    (idx_addr)
    );

    bta_select #(.ADDR_W(A_W)) u_sel (
        .sel       (dec.sel),
        .page_addr (page_addr),
        .long_addr (long_i),
        .rel_addr  (rel_addr),
        .idx_addr  (idx_addr),
        .seq_addr  (pc_next_i),
        .chosen    (chosen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            target_o <= '0;
            taken_o  <= 1'b0;
        end else if (valid_i) begin
            target_o <= chosen;
            taken_o  <= dec.taken;
        end
    end
endmodule

// File: rtl/bta_gen_chk.sv
module bta_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [2:0]  cls_i,
    input logic        cond_i,
    input logic [15:0] pc_next_i,
    input logic [10:0] page_i,
    input logic [15:0] long_i,
    input logic [7:0]  disp_i,
    input logic [7:0]  acc_i,
    input logic [15:0] dptr_i,
    input logic [15:0] target_o,
    input logic        taken_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (target_o == 16'h0000 && !taken_o));

    // R2
    page_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i == 3'd0) |=>
        (taken_o && target_o[10:0] == $past(page_i)
                 && target_o[15:11] == $past(pc_next_i[15:11])));

    // R4
    long_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i == 3'd1) |=> (taken_o && target_o == $past(long_i)));

    // R6
    cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i == 3'd3 && cond_i) |=>
        (taken_o && target_o == $past(pc_next_i) + {{8{$past(disp_i[7])}}, $past(disp_i)}));

    // R7
    cond_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i == 3'd3 && !cond_i) |=>
        (!taken_o && target_o == $past(pc_next_i)));

    // R8
    index_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i == 3'd4) |=>
        (taken_o && target_o == $past(dptr_i) + {8'h00, $past(acc_i)}));

    // R9
    spare_cls_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && cls_i > 3'd4) |=> (!taken_o && target_o == $past(pc_next_i)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(target_o) && $stable(taken_o)));
endmodule

bind bta_gen bta_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .cls_i     (cls_i),
    .cond_i    (cond_i),
    .pc_next_i (pc_next_i),
    .page_i    (page_i),
    .long_i    (long_i),
    .disp_i    (disp_i),
    .acc_i     (acc_i),
    .dptr_i    (dptr_i),
    .target_o  (target_o),
    .taken_o   (taken_o)
);

// File: tb/tb_bta_gen.sv
`timescale 1ns/100ps
module tb_bta_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  cls_i;
    logic        cond_i;
    logic [15:0] pc_next_i;
    logic [10:0] page_i;
    logic [15:0] long_i;
    logic [7:0]  disp_i;
    logic [7:0]  acc_i;
    logic [15:0] dptr_i;
    logic [15:0] target_o;
    logic        taken_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] exp_t;
    logic        exp_k;

    always #2.5 clk = ~clk;

    bta_gen dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .cls_i(cls_i), .cond_i(cond_i),
        .pc_next_i(pc_next_i), .page_i(page_i), .long_i(long_i), .disp_i(disp_i),
        .acc_i(acc_i), .dptr_i(dptr_i), .target_o(target_o), .taken_o(taken_o)
    );

    function automatic logic [15:0] model_target(input logic [2:0] c, input logic cd,
        input logic [15:0] pc, input logic [10:0] pg, input logic [15:0] lg,
        input logic [7:0] d, input logic [7:0] a, input logic [15:0] dp);
        int s;
        case (c)
            3'd0: return {pc[15:11], pg};
            3'd1: return lg;
            3'd2: begin s = int'(pc) + int'($signed(d)); return s[15:0]; end
            3'd3: begin
                if (!cd) return pc;
                s = int'(pc) + int'($signed(d)); return s[15:0];
            end
            3'd4: begin s = int'(dp) + int'(a); return s[15:0]; end
            default: return pc;
        endcase
    endfunction

    function automatic logic model_taken(input logic [2:0] c, input logic cd);
        if (c <= 3'd2 || c == 3'd4) return 1'b1;
        if (c == 3'd3) return cd;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [15:0] et, input logic ek);
        total++;
        if (target_o !== et || taken_o !== ek) begin
            bad++;
            $display("FAIL %s: target=%h taken=%b expected target=%h taken=%b",
                     req, target_o, taken_o, et, ek);
        end
    endtask

    // Drive at the falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic xfer(input string req, input logic v, input logic [2:0] c, input logic cd,
        input logic [15:0] pc, input logic [10:0] pg, input logic [15:0] lg,
        input logic [7:0] d, input logic [7:0] a, input logic [15:0] dp);
        @(negedge clk);
        valid_i = v; cls_i = c; cond_i = cd; pc_next_i = pc; page_i = pg;
        long_i = lg; disp_i = d; acc_i = a; dptr_i = dp;
        if (v) begin
            exp_t = model_target(c, cd, pc, pg, lg, d, a, dp);
            exp_k = model_taken(c, cd);
        end
        @(negedge clk);
        check(req, exp_t, exp_k);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: target=%h taken=%b expected run to finish", target_o, taken_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        rst = 1'b1; valid_i = 1'b0; cls_i = '0; cond_i = 1'b0; pc_next_i = '0;
        page_i = '0; long_i = '0; disp_i = '0; acc_i = '0; dptr_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        exp_t = 16'h0000; exp_k = 1'b0;
        check("R1", exp_t, exp_k);
        rst = 1'b0;

        // R2: in-page absolute, cond low does not matter
        xfer("R2", 1, 3'd0, 0, 16'h1234, 11'h5AB, 16'h0, 8'h0, 8'h0, 16'h0);
        // R3: transfer at 0x07FE, advanced pc 0x0800 lands in the next page
        xfer("R3", 1, 3'd0, 1, 16'h0800, 11'h010, 16'h0, 8'h0, 8'h0, 16'h0);
        xfer("R3", 1, 3'd0, 0, 16'hF800, 11'h7FF, 16'h0, 8'h0, 8'h0, 16'h0);
        // R4: long
        xfer("R4", 1, 3'd1, 0, 16'h0002, 11'h0, 16'hBEEF, 8'h0, 8'h0, 16'h0);
        // R5: backward wrap below zero and forward wrap past 0xFFFF
        xfer("R5", 1, 3'd2, 0, 16'h0010, 11'h0, 16'h0, 8'h80, 8'h0, 16'h0);
        xfer("R5", 1, 3'd2, 1, 16'hFFF0, 11'h0, 16'h0, 8'h7F, 8'h0, 16'h0);
        // R6: conditional taken
        xfer("R6", 1, 3'd3, 1, 16'h4000, 11'h0, 16'h0, 8'hFE, 8'h0, 16'h0);
        // R7: conditional not taken
        xfer("R7", 1, 3'd3, 0, 16'h4000, 11'h0, 16'h0, 8'hFE, 8'h0, 16'h0);
        // R8: indexed, acc treated as unsigned, wrap past top
        xfer("R8", 1, 3'd4, 0, 16'h0, 11'h0, 16'h0, 8'h0, 8'h80, 16'h1000);
        xfer("R8", 1, 3'd4, 1, 16'h0, 11'h0, 16'h0, 8'h0, 8'hFF, 16'hFFF0);
        // R9: spare class codes
        xfer("R9", 1, 3'd5, 1, 16'hA5A5, 11'h7FF, 16'hFFFF, 8'h7F, 8'hFF, 16'hFFFF);
        xfer("R9", 1, 3'd7, 1, 16'h0101, 11'h123, 16'h1111, 8'h01, 8'h01, 16'h2222);
        // R10: valid low keeps the previous capture
        xfer("R8", 1, 3'd4, 0, 16'h0, 11'h0, 16'h0, 8'h0, 8'h21, 16'h3000);
        xfer("R10", 0, 3'd1, 0, 16'h0, 11'h0, 16'hDEAD, 8'h0, 8'h0, 16'h0);
        xfer("R10", 0, 3'd3, 0, 16'h7777, 11'h0, 16'h0, 8'h0, 8'h0, 16'h0);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            logic v;
            string tag;
            c = 3'($urandom);
            v = ($urandom % 4) != 0;
            if (!v)             tag = "R10";
            else case (c)
                3'd0: tag = "R2";
                3'd1: tag = "R4";
                3'd2: tag = "R5";
                3'd3: tag = "R6/R7";
                3'd4: tag = "R8";
                default: tag = "R9";
            endcase
            xfer(tag, v, c, 1'($urandom), 16'($urandom), 11'($urandom), 16'($urandom),
                 8'($urandom), 8'($urandom), 16'($urandom));
        end

        // R1: reset mid-run clears the registered result
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule